// File: doc/BRIEF.md
# Dual-Rail Hardened Register Stage

This block is a register stage in which every data bit exists twice. Two separate copies of the value (rail A and rail B) come in on two sets of inputs and leave on two sets of outputs. It is built for logic that must tolerate short disturbances. A short glitch that hits one copy only makes the two copies disagree. The stage then keeps the value it already holds and does not take the corrupted one. Unlike a three-copy voting scheme, no majority decision is made. A bit is only updated when both of its copies present the same value.

In front of the register sits the next-state logic, also built twice. Rail A of the logic sees only rail A of the upstream register outputs, and rail B sees only rail B. Each rail adds a shared step operand to its own upstream copy. The capture enable also comes as two copies, one per rail, which stands for the two independent clock-buffer paths. Each bit is a master stage that decides between the new value and the held value, followed by a slave stage that stores both copies. Per-rail invert masks let a testbench corrupt one copy of any chosen bit for one cycle.

A one-cycle mismatch flag reports each enabled edge at which the copies disagreed. Reset is synchronous and clears both copies of every bit to the same configured value.

Top module: `dual_rail_hreg`

## Requirements
- R1: While `rst` is high at a clock edge, both output rails become `RST_VAL` and `mismatch` becomes 0, regardless of all other inputs.
- R2: When both enable copies are 1 and the two rails agree on every bit, both output rails show (`up_a` + `step`) mod 2^W one cycle after the edge.
- R3: The agree-or-hold decision is made per bit. A bit whose two data copies differ keeps its previous value, while the agreeing bits update in the same edge.
- R4: Outside reset, `q_a` and `q_b` are always equal.
- R5: Rail A of the logic uses only `up_a` and rail B uses only `up_b`. A bit where (`up_a`+`step`) and (`up_b`+`step`) differ therefore holds its value.
- R6: When the two enable copies differ, no bit changes, and `mismatch` is 1 in the following cycle.
- R7: `mismatch` is 1 for exactly the cycle after an edge at which the enable copies differed, or at which both enables were 1 and at least one bit disagreed. Otherwise it is 0.
- R8: A 1 in bit i of `flip_a` (or `flip_b`) inverts that rail's copy of bit i at the register input for that cycle only. If only one rail is flipped, bit i holds.
- R9: When both enable copies are 0, all bits hold and `mismatch` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cen_a | input | 1 | Capture enable, rail A copy |
| cen_b | input | 1 | Capture enable, rail B copy |
| up_a | input | W | Upstream register value, rail A |
| up_b | input | W | Upstream register value, rail B |
| step | input | W | Operand added by both logic rails |
| flip_a | input | W | Fault-injection invert mask, rail A |
| flip_b | input | W | Fault-injection invert mask, rail B |
| q_a | output | W | Stored value, rail A |
| q_b | output | W | Stored value, rail B |
| mismatch | output | 1 | Registered disagreement flag |

## Verification
A wrong hold-or-capture decision shows at `q_a`/`q_b` one cycle after the offending edge. It also stays there until the next agreeing capture, so the error persists through the following held cycles. A rail leaking into the other rail's logic shows up when the two upstream rails deliberately differ: bits that should hold take a new value instead. A wrong flag shows at `mismatch` in the very next cycle. A divergence between the stored copies is visible at once, because the two output rails differ.

// File: rtl/hreg_pkg.sv
package hreg_pkg;

  // One stored bit carried as two independent copies.
  typedef struct packed {
    logic a;
    logic b;
  } dual_bit_t;

  // Capture is legal only when both enable copies and both data copies agree.
  function automatic logic both_agree(input logic en_a, input logic en_b,
                                      input logic d_a, input logic d_b);
    return en_a & en_b & ~(d_a ^ d_b);
  endfunction

endpackage

// File: rtl/hreg_logic.sv
// One rail of the duplicated next-state logic: sees only its own rail.
module hreg_logic #(
  parameter int W = 8
) (
  input  logic [W-1:0] up,
  input  logic [W-1:0] step,
  input  logic [W-1:0] flip,
  output logic [W-1:0] nxt
);
  logic [W-1:0] sum;

  always_comb begin
    sum = up + step;
    nxt = sum ^ flip;
  end
endmodule

// File: rtl/hreg_cell.sv
// One bit: master stage (agree-or-hold select) feeding a slave stage that stores both copies.
module hreg_cell
  import hreg_pkg::*;
#(
  parameter logic RST_BIT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic en_a,
  input  logic en_b,
  input  logic d_a,
  input  logic d_b,
  output logic q_a,
  output logic q_b,
  output logic disagree
);
  dual_bit_t slv;
  dual_bit_t mst;
  logic      load_a;
  logic      load_b;

  // Each rail evaluates the load condition on its own path.
  always_comb begin
    load_a   = both_agree(en_a, en_b, d_a, d_b);
    load_b   = both_agree(en_b, en_a, d_b, d_a);
    mst.a    = load_a ? d_a : slv.a;
    mst.b    = load_b ? d_b : slv.b;
    disagree = d_a ^ d_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slv.a <= RST_BIT;
      slv.b <= RST_BIT;
    end else begin
      slv <= mst;
    end
  end

  assign q_a = slv.a;
  assign q_b = slv.b;

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(en_a && en_b && (d_a == d_b))) |-> (q_a == $past(d_a) && q_b == $past(d_b)));

  a_r3_hold_on_disagree: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(d_a != d_b)) |-> ($stable(q_a) && $stable(q_b)));

  a_r6_hold_on_enable_split: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(en_a != en_b)) |-> ($stable(q_a) && $stable(q_b)));
endmodule

// File: rtl/dual_rail_hreg.sv
module dual_rail_hreg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cen_a,
  input  logic         cen_b,
  input  logic [W-1:0] up_a,
  input  logic [W-1:0] up_b,
  input  logic [W-1:0] step,
  input  logic [W-1:0] flip_a,
  input  logic [W-1:0] flip_b,
  output logic [W-1:0] q_a,
  output logic [W-1:0] q_b,
  output logic         mismatch
);
  localparam int NRAIL = 2;

  logic [NRAIL-1:0][W-1:0] up_r;
  logic [NRAIL-1:0][W-1:0] flip_r;
  logic [NRAIL-1:0][W-1:0] nxt_r;
  logic [W-1:0]            dis;
  logic                    mism_d;
  logic                    mism_q;

  assign up_r[0]   = up_a;
  assign up_r[1]   = up_b;
  assign flip_r[0] = flip_a;
  assign flip_r[1] = flip_b;

  for (genvar r = 0; r < NRAIL; r++) begin : g_rail
    hreg_logic #(.W(W)) u_logic (
      .up   (up_r[r]),
      .step (step),
      .flip (flip_r[r]),
      .nxt  (nxt_r[r])
    );
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    hreg_cell #(.RST_BIT(RST_VAL[i])) u_cell (
      .clk      (clk),
      .rst      (rst),
      .en_a     (cen_a),
      .en_b     (cen_b),
      .d_a      (nxt_r[0][i]),
      .d_b      (nxt_r[1][i]),
      .q_a      (q_a[i]),
      .q_b      (q_b[i]),
      .disagree (dis[i])
    );
  end

  always_comb begin
    mism_d = (cen_a ^ cen_b) | (cen_a & cen_b & (|dis));
  end

  always_ff @(posedge clk) begin
    if (rst) mism_q <= 1'b0;
    else     mism_q <= mism_d;
  end

  assign mismatch = mism_q;

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (q_a == RST_VAL && q_b == RST_VAL && !mismatch));

  a_r4_rails_equal: assert property (@(posedge clk) disable iff (rst)
    q_a == q_b);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(!cen_a && !cen_b)) |-> (!mismatch && $stable(q_a)));

  a_r7_clean_no_flag: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(cen_a && cen_b && up_a == up_b && flip_a == '0 && flip_b == '0))
      |-> (!mismatch && q_a == $past(up_a + step)));
endmodule

// File: tb/test_dual_rail_hreg.sv
module test_dual_rail_hreg;
  localparam int           W    = 4;
  localparam logic [W-1:0] RSTV = 4'hA;
  localparam logic [W-1:0] MSK  = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cen_a = 1'b0, cen_b = 1'b0;
  logic [W-1:0] up_a = '0, up_b = '0, step = '0, flip_a = '0, flip_b = '0;
  logic [W-1:0] q_a, q_b;
  logic         mismatch;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] exp_q = RSTV;
  logic         exp_m = 1'b0;

  always #5 clk = ~clk;

  dual_rail_hreg #(.W(W), .RST_VAL(RSTV)) i_dual_rail_hreg (
    .clk(clk), .rst(rst), .cen_a(cen_a), .cen_b(cen_b),
    .up_a(up_a), .up_b(up_b), .step(step), .flip_a(flip_a), .flip_b(flip_b),
    .q_a(q_a), .q_b(q_b), .mismatch(mismatch)
  );

  task automatic check(input string tag);
    n_chk++;
    if (q_a !== exp_q || q_b !== exp_q || mismatch !== exp_m) begin
      n_bad++;
      $display("FAIL %s: q_a=%h q_b=%h mismatch=%b expected q=%h mismatch=%b",
               tag, q_a, q_b, mismatch, exp_q, exp_m);
    end
  endtask

  // Drive at a falling edge, update the arithmetic model, check at the next falling edge.
  task automatic cyc(input logic r, input logic ca, input logic cb,
                     input logic [W-1:0] ua, input logic [W-1:0] ub,
                     input logic [W-1:0] st, input logic [W-1:0] fa,
                     input logic [W-1:0] fb, input string tag);
    logic [W-1:0] da, db, df;
    rst = r; cen_a = ca; cen_b = cb; up_a = ua; up_b = ub;
    step = st; flip_a = fa; flip_b = fb;
    da = ((ua + st) & MSK) ^ fa;
    db = ((ub + st) & MSK) ^ fb;
    df = da ^ db;
    if (r) begin
      exp_q = RSTV; exp_m = 1'b0;
    end else if (ca && cb) begin
      exp_q = (exp_q & df) | (da & ~df);
      exp_m = (df != '0);
    end else if (ca != cb) begin
      exp_m = 1'b1;
    end else begin
      exp_m = 1'b0;
    end
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++; n_chk++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: reset state with busy inputs
    cyc(1'b1, 1'b1, 1'b1, 4'h3, 4'h3, 4'h1, 4'h0, 4'h0, "R1");

    // R2 / R4: clean captures over every operand pair
    for (int u = 0; u < 16; u++)
      for (int s = 0; s < 16; s++)
        cyc(1'b0, 1'b1, 1'b1, W'(u), W'(u), W'(s), 4'h0, 4'h0, "R2");

    // R8 / R3: one-rail invert masks, rail chosen by parity
    for (int u = 0; u < 16; u++)
      for (int f = 0; f < 16; f++) begin
        if (f[0]) cyc(1'b0, 1'b1, 1'b1, W'(u), W'(u), 4'h5, W'(f), 4'h0, "R8");
        else      cyc(1'b0, 1'b1, 1'b1, W'(u), W'(u), 4'h5, 4'h0, W'(f), "R3");
      end

    // R8: same flip on both rails is accepted
    cyc(1'b0, 1'b1, 1'b1, 4'h2, 4'h2, 4'h1, 4'h9, 4'h9, "R8");

    // R5: rails carry different upstream values
    for (int u = 0; u < 16; u++)
      for (int k = 0; k < 16; k++)
        cyc(1'b0, 1'b1, 1'b1, W'(u), W'(u) ^ W'(k), W'(k + u), 4'h0, 4'h0, "R5");

    // R6 / R7: split enables with fresh data
    cyc(1'b0, 1'b1, 1'b1, 4'h0, 4'h0, 4'h6, 4'h0, 4'h0, "R2");
    cyc(1'b0, 1'b1, 1'b0, 4'h7, 4'h7, 4'h7, 4'h0, 4'h0, "R6");
    cyc(1'b0, 1'b0, 1'b1, 4'h1, 4'h1, 4'h8, 4'h0, 4'h0, "R6");
    cyc(1'b0, 1'b1, 1'b0, 4'h1, 4'h1, 4'h8, 4'hF, 4'h0, "R7");

    // R9: both enables low
    cyc(1'b0, 1'b0, 1'b0, 4'hC, 4'h3, 4'h2, 4'h4, 4'h1, "R9");
    cyc(1'b0, 1'b0, 1'b0, 4'h9, 4'h9, 4'h0, 4'h0, 4'h0, "R9");

    // R7: flag pulses only one cycle
    cyc(1'b0, 1'b1, 1'b1, 4'h4, 4'h4, 4'h0, 4'h2, 4'h0, "R7");
    cyc(1'b0, 1'b1, 1'b1, 4'h4, 4'h4, 4'h0, 4'h0, 4'h0, "R7");

    // R1: reset mid-run
    cyc(1'b1, 1'b1, 1'b1, 4'h5, 4'h5, 4'h5, 4'h0, 4'h0, "R1");
    cyc(1'b0, 1'b0, 1'b0, 4'h5, 4'h5, 4'h5, 4'h0, 4'h0, "R1");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule